// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when an SDRAM controller should spend a command slot on an auto-refresh. It does not issue refreshes on a fixed period. Instead it keeps a count of refreshes that are owed, called the debt. The debt grows by one on every tick of an internal timer. That timer runs at the average rate the memory needs, which is one refresh about every 7.8 µs, or 8192 refreshes in each 64 ms. The debt shrinks by one for every refresh that the command arbiter acknowledges.

The memory may receive its refreshes in any spacing, as long as the total count is met. While the arbiter reports that it is serving traffic, the scheduler stays quiet and lets the debt build up. When the arbiter goes idle, the scheduler requests refreshes and pays the debt back in a run. If the debt climbs to a high-water mark, an urgent flag tells the arbiter to put refresh ahead of new accesses. That flag stays set until the debt falls below a separate low-water mark.

After reset the debt starts at a configurable value, so that a run of refreshes happens before normal traffic begins. The tick period is a parameter given in clock cycles.

Top module: `sdram_refresh_sched`

## Requirements
- R1: On reset the debt is loaded with INIT_DEBT (default 8192). When INIT_DEBT is at or above HIGH_MARK, the urgent flag is set straight after reset. The forced run then pays back INIT_DEBT-LOW_MARK+1 refreshes before the flag drops.
- R2: The debt grows by exactly one each time the tick timer completes a period of TICK_CYCLES clock cycles (default 975, about 7.8 µs at 125 MHz). This holds only when no acknowledge arrives in that same cycle and the debt is below DEBT_MAX.
- R3: Each cycle with the acknowledge high lowers the debt by one. An acknowledge while the debt is zero is ignored, and the debt never wraps below zero.
- R4: The debt saturates at DEBT_MAX (default 8192). Ticks that arrive at the maximum are dropped.
- R5: When the urgent flag is clear, the refresh request is high exactly when the debt is non-zero and the busy input is low. While busy is high, the request is held low.
- R6: The urgent flag is high in every cycle in which the debt is at or above HIGH_MARK (default 6144).
- R7: Once set, the urgent flag stays high while the debt is at or above LOW_MARK (default 2048). It clears when the debt falls below LOW_MARK, and it stays clear until the debt again reaches HIGH_MARK.
- R8: While the urgent flag is high and the debt is non-zero, the refresh request is high, whatever the busy input says.
- R9: A tick and an acknowledge in the same cycle leave the debt unchanged, provided the debt is strictly between zero and DEBT_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | High while the command arbiter is serving other traffic |
| ref_ack_i | input | 1 | One-cycle pulse for each refresh the arbiter has issued |
| ref_req_o | output | 1 | Asks the arbiter for a refresh |
| urgent_o | output | 1 | Refresh must be granted ahead of new accesses |

## Verification
The bench builds the block with TICK_CYCLES=40, DEBT_MAX=12, HIGH_MARK=10, LOW_MARK=4 and INIT_DEBT=10. With these values a tick arrives every 40 cycles, so the saturation limit, both water marks and the start-up run are all reached within a few hundred cycles. The debt is read back only through the ports: the bench counts the acknowledges needed until the request drops. It also runs a model of the debt, built from the requirements, and compares the request and urgent outputs with that model in every cycle.

// File: rtl/sdram_refresh_sched_pkg.sv
package sdram_refresh_sched_pkg;

  // Next debt value: a tick adds one below the limit, an ack removes one above zero.
  function automatic int unsigned debt_step(input int unsigned d, input logic up,
                                            input logic dn, input int unsigned lim);
    int unsigned r;
    r = d;
    if (up && (d < lim)) r = r + 1;
    if (dn && (d > 0))   r = r - 1;
    return r;
  endfunction

  // Hysteresis: set at or above hi, hold while at or above lo.
  function automatic logic urgent_eval(input int unsigned d, input logic held,
                                       input int unsigned hi, input int unsigned lo);
    return (d >= hi) || (held && (d >= lo));
  endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int TICK_CYCLES = 975
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr
  import sdram_refresh_sched_pkg::*;
#(
  parameter int DEBT_MAX  = 8192,
  parameter int INIT_DEBT = 8192,
  parameter int DW        = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          ack_i,
  output logic [DW-1:0] debt_o
);
  logic [DW-1:0] debt_q;
  logic [DW-1:0] debt_d;

  always_comb debt_d = DW'(debt_step(32'(debt_q), tick_i, ack_i, DEBT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= DW'(INIT_DEBT);
    else        debt_q <= debt_d;
  end

  assign debt_o = debt_q;
endmodule

// File: rtl/refresh_urgency.sv
module refresh_urgency
  import sdram_refresh_sched_pkg::*;
#(
  parameter int HIGH_MARK = 6144,
  parameter int LOW_MARK  = 2048,
  parameter int DW        = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] debt_i,
  output logic          urgent_o
);
  logic held_q;

  assign urgent_o = urgent_eval(32'(debt_i), held_q, HIGH_MARK, LOW_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= urgent_o;
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int TICK_CYCLES = 975,
  parameter int DEBT_MAX    = 8192,
  parameter int HIGH_MARK   = 6144,
  parameter int LOW_MARK    = 2048,
  parameter int INIT_DEBT   = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic ref_ack_i,
  output logic ref_req_o,
  output logic urgent_o
);
  localparam int DW = $clog2(DEBT_MAX + 1);

  logic          tick_w;
  logic [DW-1:0] debt_w;

  refresh_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  refresh_debt_ctr #(.DEBT_MAX(DEBT_MAX), .INIT_DEBT(INIT_DEBT), .DW(DW)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .ack_i(ref_ack_i), .debt_o(debt_w)
  );

  refresh_urgency #(.HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK), .DW(DW)) u_urg (
    .clk(clk), .rst_n(rst_n), .debt_i(debt_w), .urgent_o(urgent_o)
  );

  // Ask when owed and either the arbiter is idle or the debt is urgent.
  assign ref_req_o = (debt_w != '0) && (!busy_i || urgent_o);
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int DEBT_MAX  = 8192,
  parameter int HIGH_MARK = 6144,
  parameter int LOW_MARK  = 2048,
  parameter int DW        = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          ref_ack_i,
  input logic          ref_req_o,
  input logic          urgent_o,
  input logic          tick_w,
  input logic [DW-1:0] debt_w
);
  assert_tick_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && !ref_ack_i && (32'(debt_w) < DEBT_MAX)) |=> (debt_w == $past(debt_w) + 1'b1));

  assert_ack_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ack_i && !tick_w && (debt_w != '0)) |=> (debt_w == $past(debt_w) - 1'b1));

  assert_ack_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ack_i && !tick_w && (debt_w == '0)) |=> (debt_w == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(debt_w) <= DEBT_MAX);

  assert_busy_holds_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !urgent_o) |-> !ref_req_o);

  assert_urgent_at_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(debt_w) >= HIGH_MARK) |-> urgent_o);

  assert_urgent_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(urgent_o) |-> (32'(debt_w) < LOW_MARK));

  assert_urgent_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_o && (debt_w != '0)) |-> ref_req_o);

  assert_pair_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_w && ref_ack_i && (debt_w != '0) && (32'(debt_w) < DEBT_MAX)) |=> $stable(debt_w));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .DEBT_MAX(DEBT_MAX), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK), .DW(DW)
) u_chk (.*);

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;
  localparam int T    = 40;
  localparam int MAXD = 12;
  localparam int HI   = 10;
  localparam int LO   = 4;
  localparam int INIT = 10;

  logic clk, rst_n, busy, ack;
  logic ref_req, urgent;
  int   n_checks = 0;
  int   n_err = 0;
  bit   done = 0;

  sdram_refresh_sched #(.TICK_CYCLES(T), .DEBT_MAX(MAXD), .HIGH_MARK(HI),
                        .LOW_MARK(LO), .INIT_DEBT(INIT)) i_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .ref_ack_i(ack),
    .ref_req_o(ref_req), .urgent_o(urgent)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bench model written from the requirements.
  int m_cnt, m_debt;
  bit m_held;
  bit m_urg, m_req;
  always_comb begin
    m_urg = (m_debt >= HI) || (m_held && (m_debt >= LO));
    m_req = (m_debt != 0) && (!busy || m_urg);
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_debt <= INIT; m_held <= 0;
    end else begin
      m_cnt  <= (m_cnt == T-1) ? 0 : m_cnt + 1;
      m_debt <= m_debt + (((m_cnt == T-1) && m_debt < MAXD) ? 1 : 0)
                       - ((ack && m_debt > 0) ? 1 : 0);
      m_held <= m_urg;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(ref_req == m_req, "R5 R8 request vs model", ref_req, m_req);
    check(urgent == m_urg, "R6 R7 urgent vs model", urgent, m_urg);
  end

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Ack while requested; returns the number of acks until the request drops.
  task automatic drain(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (!ref_req) break;
      ack = 1'b1;
      @(posedge clk); #1;
      ack = 1'b0;
      n++;
    end
  endtask

  // Returns just after a tick has been counted.
  task automatic wait_tick();
    @(negedge clk);
    while (m_cnt != 0) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0; busy = 1'b1; ack = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(urgent == 1'b1, "R1 urgent after reset", urgent, 1);
    check(ref_req == 1'b1, "R8 request forced while busy", ref_req, 1);
    #1 drain(n);
    check(n == INIT-LO+1, "R1 forced start-up run length", n, INIT-LO+1);
    check(urgent == 1'b0, "R7 urgent clears below low mark", urgent, 0);
    busy = 1'b0;
    drain(n);
    check(n == LO-1, "R5 idle drains the rest", n, LO-1);
  endtask

  task automatic t_ack_zero();
    int n;
    @(negedge clk);
    while (m_cnt == T-1 || m_cnt == T-2) @(negedge clk);
    #1 ack = 1'b1;
    @(posedge clk); #1 ack = 1'b0;
    busy = 1'b1;
    wait_tick();
    busy = 1'b0;
    drain(n);
    check(n == 1, "R3 ack at zero ignored", n, 1);
  endtask

  task automatic t_holdoff();
    int n;
    busy = 1'b1;
    repeat (3) wait_tick();
    @(negedge clk);
    check(ref_req == 1'b0, "R5 held off while busy", ref_req, 0);
    check(urgent == 1'b0, "R6 not urgent below high mark", urgent, 0);
    #1 busy = 1'b0;
    drain(n);
    check(n == 3, "R2 one debt per tick", n, 3);
  endtask

  task automatic t_urgent();
    int n;
    busy = 1'b1;
    for (int i = 0; i < 20 && m_debt < HI; i++) wait_tick();
    @(negedge clk);
    check(urgent == 1'b1, "R6 urgent at high mark", urgent, 1);
    check(ref_req == 1'b1, "R8 request while busy and urgent", ref_req, 1);
    #1 drain(n);
    check(n == HI-LO+1, "R7 urgent held down to low mark", n, HI-LO+1);
    wait_tick();
    @(negedge clk);
    check(urgent == 1'b0, "R7 no re-arm at low mark", urgent, 0);
    check(ref_req == 1'b0, "R5 busy holds off at low mark", ref_req, 0);
    #1 busy = 1'b0;
    drain(n);
    check(n == LO, "R2 R3 remaining debt", n, LO);
  endtask

  task automatic t_saturate();
    int n;
    busy = 1'b1;
    repeat (MAXD + 4) wait_tick();
    busy = 1'b0;
    drain(n);
    check(n == MAXD, "R4 debt saturates", n, MAXD);
  endtask

  task automatic t_pair();
    int n;
    busy = 1'b1;
    repeat (2) wait_tick();
    @(negedge clk);
    while (m_cnt != T-1) @(negedge clk);
    #1 ack = 1'b1;
    @(posedge clk); #1 ack = 1'b0;
    busy = 1'b0;
    drain(n);
    check(n == 2, "R9 tick and ack cancel", n, 2);
  endtask

  initial begin
    t_reset();
    t_ack_zero();
    t_holdoff();
    t_urgent();
    t_saturate();
    t_pair();
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_up();
    end
  end
endmodule